// File: doc/BRIEF.md
# Port Switch Overcurrent Timeout and Fault Recovery

This block guards the power switch of one powered-Ethernet port. It measures, in units of a 1 ms tick, how long the port has stayed in current limit without a break. When that time reaches the overcurrent limit, or when the die reports over-temperature, it turns the switch off and raises a fault flag. It then applies one of two recovery policies. Latch mode waits for the operator to cycle the enable input. Auto-retry mode waits for the fault condition itself to clear. Both policies then hold off for a fixed restart delay before they ask the port sequencer to start again.

The block also produces the current-limit threshold used by the analog limit loop. It derives that threshold from a digitized output-voltage code: the full limit applies at high output voltage, and the limit folds back to one third of full as the output voltage falls. Analog regulation and temperature sensing sit outside the block. They reach it as a comparator flag and a pair of temperature flags.

Top module: `pse_fault_guard`

## Requirements
- R1: The in-limit timer advances by one on each `tick_ms` sampled while `over_limit` is high and the port is running. Any clock cycle with `over_limit` low returns it to zero.
- R2: On the 60th consecutive counted tick, `sw_off` and `fault` both go high in the following clock cycle. After only 59 ticks they stay low.
- R3: A `temp_hot` pulse while running drives `sw_off` and `fault` high in the next cycle. The over-temperature condition stays in force until `temp_cool` is seen with `temp_hot` low.
- R4: `ilim_code` is registered one cycle after `vout_code` and is in 1 mV units, with `vout_code` at 0.25 V per LSB. It is 212 for codes of 72 and above, and 70 for codes of 8 and below. Between those codes it is 70 + floor(142·(code−8)/64).
- R5: In latch mode the switch stays off after a fault until `enable` has been low on at least 3 consecutive sampled ticks and then goes high. A shorter low pulse is ignored.
- R6: Once a valid enable toggle is seen in latch mode, `restart_req` pulses for one cycle after exactly 1920 further ticks, and not earlier.
- R7: In auto-retry mode an overcurrent fault starts the 1920-tick wait at once, with no action by the operator. A one-cycle `restart_req` ends the wait.
- R8: After an over-temperature fault, the 1920-tick wait does not start until the cool condition is seen.
- R9: `restart_direct` is high together with `restart_req` exactly when `det_skip` was high at the end of the wait. High means the sequencer goes straight to power-up; low means it runs detection first.
- R10: `fault` stays high through the wait and the restart. It clears one cycle after `power_go` is seen while the port is running. A `power_go` during the hold or the wait has no effect on it.
- R11: After reset, `sw_off`, `fault`, `restart_req` and `restart_direct` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| over_limit | input | 1 | Sense drop is above the active limit |
| temp_hot | input | 1 | Die temperature at or above the trip point |
| temp_cool | input | 1 | Die temperature below the hysteresis point |
| enable | input | 1 | Port enable; cycling it low then high releases a latched fault |
| latch_mode | input | 1 | 1 selects latch-off recovery, 0 selects auto-retry |
| det_skip | input | 1 | Detection is disabled; restart goes straight to power-up |
| power_go | input | 1 | Sequencer marks the start of a power phase |
| vout_code | input | 8 | Output voltage code, 0.25 V per LSB |
| sw_off | output | 1 | Request to turn the power switch off |
| fault | output | 1 | Latched fault flag |
| restart_req | output | 1 | One-cycle restart request to the port sequencer |
| restart_direct | output | 1 | With restart_req: skip detection |
| ilim_code | output | 8 | Foldback current-limit threshold, mV of sense drop |

## Verification
The in-limit timer can reach its limit in the same cycle that over-temperature is raised. Both causes then enter the hold state together. The bench provokes this by driving `temp_hot` high during the 60th counted tick. The correct response is a single entry into the off state in which the over-temperature rule governs recovery: no restart may follow, however long the bench waits, until `temp_cool` is given. After that exactly 1920 ticks must pass before the restart pulse. A second coincidence tested is a tick arriving while `over_limit` has just dropped, where the reset of the timer must win.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
   typedef enum logic [1:0] {
      PFG_RUN  = 2'd0,
      PFG_HOLD = 2'd1,
      PFG_WAIT = 2'd2
   } pfg_state_e;
endpackage

// File: rtl/pfg_foldback.sv
module pfg_foldback #(
   parameter int VW          = 8,
   parameter int IW          = 8,
   parameter int FULL_MV     = 212,
   parameter int FOLD_DIV    = 3,
   parameter int KNEE_CODE   = 72,
   parameter int FLOOR_CODE  = 8,
   parameter bit FOLDBACK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] vout_code,
   output logic [IW-1:0] ilim_code
);
   localparam int LOW_MV  = FULL_MV / FOLD_DIV;
   localparam int SPAN_MV = FULL_MV - LOW_MV;
   localparam int RANGE   = KNEE_CODE - FLOOR_CODE;

   logic [IW-1:0] thr_d;

   generate
      if (FOLDBACK_EN) begin : g_fold
         always_comb begin
            int unsigned v;
            int unsigned t;
            v = 32'(vout_code);
            if (v >= 32'(KNEE_CODE)) begin
               t = 32'(FULL_MV);
            end else if (v <= 32'(FLOOR_CODE)) begin
               t = 32'(LOW_MV);
            end else begin
               t = 32'(LOW_MV) + (32'(SPAN_MV) * (v - 32'(FLOOR_CODE))) / 32'(RANGE);
            end
            thr_d = IW'(t);
         end
      end else begin : g_flat
         assign thr_d = IW'(FULL_MV);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ilim_code <= IW'(LOW_MV);
      else        ilim_code <= thr_d;
   end
endmodule

// File: rtl/pfg_oc_timer.sv
module pfg_oc_timer #(
   parameter int OC_TICKS = 60,
   localparam int CW      = $clog2(OC_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_ms,
   input  logic          run,
   input  logic          over_limit,
   output logic [CW-1:0] oc_cnt,
   output logic          oc_trip
);
   assign oc_trip = run && over_limit && tick_ms && (oc_cnt == CW'(OC_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oc_cnt <= '0;
      end else if (!run || !over_limit || oc_trip) begin
         oc_cnt <= '0;
      end else if (tick_ms) begin
         oc_cnt <= oc_cnt + CW'(1);
      end
   end
endmodule

// File: rtl/pfg_en_toggle.sv
module pfg_en_toggle #(
   parameter int LOW_TICKS = 3,
   localparam int LW       = $clog2(LOW_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_ms,
   input  logic enable,
   output logic toggle
);
   logic          en_q;
   logic [LW-1:0] low_cnt;
   logic          armed;

   assign armed  = (low_cnt == LW'(LOW_TICKS));
   assign toggle = enable && !en_q && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         low_cnt <= '0;
      end else begin
         en_q <= enable;
         if (enable) begin
            low_cnt <= '0;
         end else if (tick_ms && !armed) begin
            low_cnt <= low_cnt + LW'(1);
         end
      end
   end
endmodule

// File: rtl/pfg_recovery.sv
module pfg_recovery
   import pfg_pkg::*;
#(
   parameter int RETRY_TICKS = 1920,
   localparam int WW         = $clog2(RETRY_TICKS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_ms,
   input  logic       oc_trip,
   input  logic       temp_hot,
   input  logic       temp_cool,
   input  logic       latch_mode,
   input  logic       toggle,
   input  logic       det_skip,
   input  logic       power_go,
   output pfg_state_e state,
   output logic       ot_active,
   output logic       fault,
   output logic       restart_req,
   output logic       restart_direct
);
   logic [WW-1:0] wait_cnt;
   logic          release_ok;
   logic          wait_done;

   assign release_ok = !ot_active && (!latch_mode || toggle);
   assign wait_done  = tick_ms && (wait_cnt == WW'(RETRY_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ot_active <= 1'b0;
      end else if (temp_hot) begin
         ot_active <= 1'b1;
      end else if (temp_cool) begin
         ot_active <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= PFG_RUN;
         wait_cnt       <= '0;
         fault          <= 1'b0;
         restart_req    <= 1'b0;
         restart_direct <= 1'b0;
      end else begin
         restart_req    <= 1'b0;
         restart_direct <= 1'b0;
         unique case (state)
            PFG_RUN: begin
               if (temp_hot || oc_trip) begin
                  state <= PFG_HOLD;
                  fault <= 1'b1;
               end else if (power_go) begin
                  fault <= 1'b0;
               end
            end
            PFG_HOLD: begin
               wait_cnt <= '0;
               if (!temp_hot && release_ok) state <= PFG_WAIT;
            end
            PFG_WAIT: begin
               if (temp_hot) begin
                  state    <= PFG_HOLD;
                  wait_cnt <= '0;
               end else if (wait_done) begin
                  state          <= PFG_RUN;
                  wait_cnt       <= '0;
                  restart_req    <= 1'b1;
                  restart_direct <= det_skip;
               end else if (tick_ms) begin
                  wait_cnt <= wait_cnt + WW'(1);
               end
            end
            default: state <= PFG_RUN;
         endcase
      end
   end
endmodule

// File: rtl/pse_fault_guard.sv
module pse_fault_guard
   import pfg_pkg::*;
#(
   parameter int VW          = 8,
   parameter int IW          = 8,
   parameter int OC_TICKS    = 60,
   parameter int RETRY_TICKS = 1920,
   parameter int EN_LOW_TICKS = 3,
   parameter int FULL_MV     = 212,
   parameter int FOLD_DIV    = 3,
   parameter int KNEE_CODE   = 72,
   parameter int FLOOR_CODE  = 8,
   parameter bit FOLDBACK_EN = 1'b1,
   localparam int CW         = $clog2(OC_TICKS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_ms,
   input  logic          over_limit,
   input  logic          temp_hot,
   input  logic          temp_cool,
   input  logic          enable,
   input  logic          latch_mode,
   input  logic          det_skip,
   input  logic          power_go,
   input  logic [VW-1:0] vout_code,
   output logic          sw_off,
   output logic          fault,
   output logic          restart_req,
   output logic          restart_direct,
   output logic [IW-1:0] ilim_code
);
   generate
      if (OC_TICKS < 2)                        begin : g_bad_oc   $error("OC_TICKS too small");   end
      if (RETRY_TICKS < 2)                     begin : g_bad_rt   $error("RETRY_TICKS too small"); end
      if (EN_LOW_TICKS < 1)                    begin : g_bad_en   $error("EN_LOW_TICKS too small"); end
      if (KNEE_CODE <= FLOOR_CODE)             begin : g_bad_knee $error("knee must exceed floor"); end
      if (KNEE_CODE >= (1 << VW))              begin : g_bad_vw   $error("knee outside code range"); end
      if (FULL_MV >= (1 << IW))                begin : g_bad_iw   $error("limit outside code range"); end
      if (FOLD_DIV < 1)                        begin : g_bad_div  $error("FOLD_DIV must be positive"); end
   endgenerate

   pfg_state_e    state;
   logic          ot_active;
   logic          oc_trip;
   logic [CW-1:0] oc_cnt;
   logic          toggle;
   logic          run;

   assign run    = (state == PFG_RUN);
   assign sw_off = !run;

   pfg_foldback #(
      .VW(VW), .IW(IW), .FULL_MV(FULL_MV), .FOLD_DIV(FOLD_DIV),
      .KNEE_CODE(KNEE_CODE), .FLOOR_CODE(FLOOR_CODE), .FOLDBACK_EN(FOLDBACK_EN)
   ) u_fold (
      .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .ilim_code(ilim_code)
   );

   pfg_oc_timer #(.OC_TICKS(OC_TICKS)) u_oc (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .run(run),
      .over_limit(over_limit), .oc_cnt(oc_cnt), .oc_trip(oc_trip)
   );

   pfg_en_toggle #(.LOW_TICKS(EN_LOW_TICKS)) u_tog (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .enable(enable), .toggle(toggle)
   );

   pfg_recovery #(.RETRY_TICKS(RETRY_TICKS)) u_rec (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .oc_trip(oc_trip),
      .temp_hot(temp_hot), .temp_cool(temp_cool), .latch_mode(latch_mode),
      .toggle(toggle), .det_skip(det_skip), .power_go(power_go),
      .state(state), .ot_active(ot_active), .fault(fault),
      .restart_req(restart_req), .restart_direct(restart_direct)
   );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
   parameter int IW      = 8,
   parameter int CW      = 6,
   parameter int FULL_MV = 212,
   parameter int LOW_MV  = 70
) (
   input logic          clk,
   input logic          rst_n,
   input logic          over_limit,
   input logic          temp_hot,
   input logic          oc_trip,
   input logic [CW-1:0] oc_cnt,
   input logic          ot_active,
   input logic          sw_off,
   input logic          fault,
   input logic          restart_req,
   input logic          power_go,
   input logic [IW-1:0] ilim_code
);
   AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !over_limit |=> (oc_cnt == '0)); // R1
   AST_OC_SHUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip |=> (sw_off && fault)); // R2
   AST_HOT_SHUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_hot && !sw_off) |=> (sw_off && fault && ot_active)); // R3
   AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ilim_code <= IW'(FULL_MV)) && (ilim_code >= IW'(LOW_MV))); // R4
   AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req); // R7
   AST_NO_RESTART_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> !ot_active); // R8
   AST_FAULT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_off && $past(sw_off) && $past(fault)) |-> fault); // R10
   AST_FAULT_ON_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault) |-> ($past(power_go) && !sw_off)); // R10
endmodule

bind pse_fault_guard pfg_checker #(
   .IW(IW), .CW(CW), .FULL_MV(FULL_MV), .LOW_MV(FULL_MV / FOLD_DIV)
) u_pfg_checker (
   .clk(clk), .rst_n(rst_n), .over_limit(over_limit), .temp_hot(temp_hot),
   .oc_trip(oc_trip), .oc_cnt(oc_cnt), .ot_active(ot_active), .sw_off(sw_off),
   .fault(fault), .restart_req(restart_req), .power_go(power_go), .ilim_code(ilim_code)
);

// File: tb/pse_fault_guard_bench.sv
`timescale 1ns/1ps
module pse_fault_guard_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_ms = 1'b0, over_limit = 1'b0, temp_hot = 1'b0, temp_cool = 1'b0;
   logic       enable = 1'b1, latch_mode = 1'b0, det_skip = 1'b0, power_go = 1'b0;
   logic [7:0] vout_code = 8'd0;
   logic       sw_off, fault, restart_req, restart_direct;
   logic [7:0] ilim_code;

   int checks = 0;
   int errors = 0;
   int restarts = 0;
   logic last_direct = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pse_fault_guard u_pse_fault_guard (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .over_limit(over_limit),
      .temp_hot(temp_hot), .temp_cool(temp_cool), .enable(enable),
      .latch_mode(latch_mode), .det_skip(det_skip), .power_go(power_go),
      .vout_code(vout_code), .sw_off(sw_off), .fault(fault),
      .restart_req(restart_req), .restart_direct(restart_direct), .ilim_code(ilim_code)
   );

   always @(negedge clk) begin
      if (rst_n && restart_req) begin
         restarts++;
         last_direct = restart_direct;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_ms = 1'b1;
         @(negedge clk) tick_ms = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; tick_ms = 0; over_limit = 0; temp_hot = 0; temp_cool = 0;
      enable = 1; latch_mode = 0; det_skip = 0; power_go = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      restarts = 0;
   endtask

   function automatic int fold_exp(input int v);
      if (v >= 72) return 212;
      if (v <= 8) return 70;
      return 70 + (142 * (v - 8)) / 64;
   endfunction

   task automatic t_reset_state();
      do_reset();
      check("R11 sw_off", sw_off, 0);
      check("R11 fault", fault, 0);
      check("R11 restart_req", restart_req, 0);
      check("R11 restart_direct", restart_direct, 0);
   endtask

   task automatic t_foldback();
      int codes[7] = '{0, 8, 9, 40, 71, 72, 255};
      do_reset();
      foreach (codes[i]) begin
         @(negedge clk) vout_code = 8'(codes[i]);
         @(negedge clk);
         check($sformatf("R4 ilim at code %0d", codes[i]), ilim_code, fold_exp(codes[i]));
      end
   endtask

   task automatic t_timer_reset();
      do_reset();
      over_limit = 1'b1;
      do_ticks(30);
      // R1: a tick arriving in the cycle the flag drops must not count
      @(negedge clk) begin over_limit = 1'b0; tick_ms = 1'b1; end
      @(negedge clk) begin tick_ms = 1'b0; over_limit = 1'b1; end
      do_ticks(59);
      check("R1 no trip after restarted count of 59", sw_off, 0);
      check("R2 no fault after 59 ticks", fault, 0);
      do_ticks(1);
      check("R2 sw_off after 60 ticks", sw_off, 1);
      check("R2 fault after 60 ticks", fault, 1);
   endtask

   task automatic t_auto_retry_oc();
      // continues from the trip of t_timer_reset, auto-retry mode
      over_limit = 1'b0;
      det_skip = 1'b1;
      @(negedge clk) power_go = 1'b1;
      @(negedge clk) power_go = 1'b0;
      check("R10 power_go ignored while off", fault, 1);
      do_ticks(1919);
      check("R7 no restart before 1920 ticks", restarts, 0);
      do_ticks(1);
      check("R7 restart after 1920 ticks", restarts, 1);
      check("R9 restart_direct follows det_skip", last_direct, 1);
      check("R10 fault held after restart", fault, 1);
      check("R7 switch released", sw_off, 0);
      @(negedge clk) power_go = 1'b1;
      @(negedge clk) power_go = 1'b0;
      check("R10 fault cleared by power_go", fault, 0);
   endtask

   task automatic t_latch();
      do_reset();
      latch_mode = 1'b1;
      det_skip = 1'b0;
      over_limit = 1'b1;
      do_ticks(60);
      over_limit = 1'b0;
      check("R5 latched off", sw_off, 1);
      enable = 1'b0;
      do_ticks(2);
      enable = 1'b1;
      do_ticks(2100);
      check("R5 short enable low ignored", restarts, 0);
      check("R5 still off", sw_off, 1);
      enable = 1'b0;
      do_ticks(3);
      enable = 1'b1;
      do_ticks(1919);
      check("R6 no restart before wait", restarts, 0);
      do_ticks(1);
      check("R6 restart after toggle and wait", restarts, 1);
      check("R9 detection path", last_direct, 0);
   endtask

   task automatic t_overtemp();
      do_reset();
      @(negedge clk) temp_hot = 1'b1;
      @(negedge clk) temp_hot = 1'b0;
      check("R3 sw_off on hot", sw_off, 1);
      check("R3 fault on hot", fault, 1);
      do_ticks(2100);
      check("R8 no restart while not cool", restarts, 0);
      check("R3 still off", sw_off, 1);
      @(negedge clk) temp_cool = 1'b1;
      @(negedge clk) temp_cool = 1'b0;
      do_ticks(1919);
      check("R8 no restart before wait", restarts, 0);
      do_ticks(1);
      check("R8 restart after cool and wait", restarts, 1);
   endtask

   task automatic t_same_cycle();
      do_reset();
      over_limit = 1'b1;
      do_ticks(59);
      @(negedge clk) begin tick_ms = 1'b1; temp_hot = 1'b1; end
      @(negedge clk) begin tick_ms = 1'b0; temp_hot = 1'b0; over_limit = 1'b0; end
      check("R2 off on coincident trip", sw_off, 1);
      do_ticks(2100);
      check("R8 coincident trip waits for cool", restarts, 0);
      @(negedge clk) temp_cool = 1'b1;
      @(negedge clk) temp_cool = 1'b0;
      do_ticks(1920);
      check("R8 coincident trip restarts", restarts, 1);
   endtask

   initial begin
      t_reset_state();
      t_foldback();
      t_timer_reset();
      t_auto_retry_oc();
      t_latch();
      t_overtemp();
      t_same_cycle();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule